// File: doc/BRIEF.md
# Event Performance Monitor

The block watches a vector of one-cycle event pulses and a free clock, and keeps three 32-bit counts. Two of them are general: each takes an 8-bit select code from the control word and counts pulses on the chosen event line. The third always counts clocks, either every cycle or once per prescaler period. A single global enable starts and stops all three together. A counter is parked by giving it a select code that never fires.

Software reaches the block through a four-entry register port. Address 0 holds the control word, 1 the cycle count, 2 the first event count and 3 the second. Reads are combinational and writes take effect at the clock edge. Each counter raises a sticky overflow flag when it wraps. The flags are cleared by writing ones, so a handler clears every flag it saw by writing back the control word it read. One interrupt line combines the flags, each gated by its own enable.

Top module: `perf_monitor`

## Requirements
- R1: After reset every register address reads zero and `irq` is low.
- R2: Control bit 0 enables all three counters together. While it is clear, no counter value changes except through a register write or a reset bit.
- R3: The select code at control bits 27:20 drives event count 0, and bits 19:12 drive event count 1. A code below 32 counts the cycles in which `events[code]` is high. Code 0xFF counts every enabled clock. Any other code, 0x20 included, counts nothing.
- R4: Writing 1 to control bit 1 zeroes both event counts, and writing 1 to bit 2 zeroes the cycle count. Neither bit is stored, so both read back as 0.
- R5: With control bit 3 set, the cycle count advances once per PRESCALE enabled clocks, counted from the last cycle-count reset. With bit 3 clear it advances every enabled clock.
- R6: A wrap from all-ones to zero sets a sticky flag: bit 8 for event count 0, bit 9 for event count 1, bit 10 for the cycle count.
- R7: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. Writing back the word just read clears the flags that were set and leaves every other stored field as it was.
- R8: `irq` is high exactly when some flag is set and its enable is set. The enables are bit 4 for event count 0, bit 5 for event count 1 and bit 6 for the cycle count.
- R9: Address 1 reads and writes the cycle count, 2 event count 0 and 3 event count 1. A write wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 count 0, 3 count 1) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| events | input | EVT_W (32) | One-cycle event pulses |
| irq | output | 1 | Shared overflow interrupt |

## Verification
The bench keeps the default 32-bit counters and 32-line event vector, so wraps are reached by preloading values near all-ones through the register port. It sets PRESCALE to 8 so that two full prescaler periods fit inside a short window. This makes the exact tick positions of the divided cycle count observable. A vector table covers in-range, dead and out-of-range select codes on both event counters.

// File: rtl/pmu_pkg.sv
// Package pmu_pkg: shared constants for the performance monitor.
// Assumes a 32-bit control word with the field layout below.
package pmu_pkg;
    localparam int CTRL_W    = 32;
    localparam int NUM_CNT   = 3;
    localparam int EN_BIT    = 0;
    localparam int RSTEV_BIT = 1;
    localparam int RSTCY_BIT = 2;
    localparam int DIV_BIT   = 3;
    localparam int IEN_LSB   = 4;
    localparam int FLAG_LSB  = 8;
    localparam int SEL1_LSB  = 12;
    localparam int SEL0_LSB  = 20;
    localparam int IDX_EV0   = 0;
    localparam int IDX_EV1   = 1;
    localparam int IDX_CYC   = 2;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CYC  = 2'd1,
        ADDR_EV0  = 2'd2,
        ADDR_EV1  = 2'd3
    } reg_addr_e;

    // Register address of counter slot idx.
    function automatic logic [1:0] slot_addr(input int idx);
        case (idx)
            IDX_EV0: slot_addr = ADDR_EV0;
            IDX_EV1: slot_addr = ADDR_EV1;
            default: slot_addr = ADDR_CYC;
        endcase
    endfunction
endpackage

// File: rtl/pmu_evsel.sv
// pmu_evsel: turns a select code into a per-cycle count strobe.
// Assumes that an all-ones code means "every cycle" and that a code at or
// beyond EVT_W selects nothing.
module pmu_evsel #(
    parameter int EVT_W = 32,
    parameter int SEL_W = 8
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [EVT_W-1:0] events,
    output logic             hit
);
    localparam int IDX_W = $clog2(EVT_W);

    // Pick the event line, the always-on code or nothing.
    always_comb begin
        if (sel == '1)
            hit = 1'b1;
        else if (int'(sel) < EVT_W)
            hit = events[sel[IDX_W-1:0]];
        else
            hit = 1'b0;
    end
endmodule

// File: rtl/pmu_prescale.sv
// pmu_prescale: gives a one-cycle tick every RATIO cycles while run is high.
// Assumes RATIO >= 2. clear restarts the period.
module pmu_prescale #(
    parameter int RATIO = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    output logic tick
);
    localparam int PW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [PW-1:0] LAST = PW'(RATIO - 1);

    logic [PW-1:0] phase;

    assign tick = run && (phase == LAST);

    // Advance the phase, wrapping after the last step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (clear)
            phase <= '0;
        else if (run)
            phase <= tick ? '0 : phase + 1'b1;
    end

    // R5
    prescale_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear) |=> (phase == '0));
endmodule

// File: rtl/pmu_counter.sv
// pmu_counter: one wrapping counter with a load port and a synchronous clear.
// Assumes the load has priority over the clear, and the clear over an increment.
module pmu_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    assign wrap = inc && !load && !clear && (value == '1);

    // Update the count: load, then clear, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value <= '0;
        else if (load)
            value <= load_val;
        else if (clear)
            value <= '0;
        else if (inc)
            value <= value + 1'b1;
    end

    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (value == $past(load_val)));
    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (value == '0));
endmodule

// File: rtl/pmu_ctrl.sv
// pmu_ctrl: holds the control word, the sticky overflow flags and the
// interrupt. Reset bits are write-only pulses. A new overflow wins over a
// clear arriving in the same cycle.
module pmu_ctrl
    import pmu_pkg::*;
#(
    parameter int SEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CTRL_W-1:0]  wdata,
    input  logic [NUM_CNT-1:0] wrap,
    output logic               run,
    output logic               divide,
    output logic [SEL_W-1:0]   sel_ev0,
    output logic [SEL_W-1:0]   sel_ev1,
    output logic               zero_ev,
    output logic               zero_cyc,
    output logic [CTRL_W-1:0]  word,
    output logic               irq
);
    logic [NUM_CNT-1:0] ien;
    logic [NUM_CNT-1:0] flags;
    logic [NUM_CNT-1:0] clr_mask;
    logic               unused_ctrl_bits;

    assign unused_ctrl_bits = ^{wdata[31:28], wdata[11], wdata[7]};
    assign zero_ev  = wr && wdata[RSTEV_BIT];
    assign zero_cyc = wr && wdata[RSTCY_BIT];
    assign clr_mask = wr ? wdata[FLAG_LSB +: NUM_CNT] : '0;
    assign irq      = |(flags & ien);

    // Capture the stored control fields on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            divide  <= 1'b0;
            ien     <= '0;
            sel_ev0 <= '0;
            sel_ev1 <= '0;
        end else if (wr) begin
            run     <= wdata[EN_BIT];
            divide  <= wdata[DIV_BIT];
            ien     <= wdata[IEN_LSB +: NUM_CNT];
            sel_ev0 <= wdata[SEL0_LSB +: SEL_W];
            sel_ev1 <= wdata[SEL1_LSB +: SEL_W];
        end
    end

    // Set flags on a wrap and clear the ones written as 1.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else
            flags <= (flags & ~clr_mask) | wrap;
    end

    // Assemble the readable control word.
    always_comb begin
        word                         = '0;
        word[EN_BIT]                 = run;
        word[DIV_BIT]                = divide;
        word[IEN_LSB +: NUM_CNT]     = ien;
        word[FLAG_LSB +: NUM_CNT]    = flags;
        word[SEL1_LSB +: SEL_W]      = sel_ev1;
        word[SEL0_LSB +: SEL_W]      = sel_ev0;
    end

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_flag_chk
        // R6
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wrap[i] |=> flags[i]);
        // R7
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(wr && wdata[FLAG_LSB + i])) |=> flags[i]);
        // R6
        flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flags[i]) |-> $past(wrap[i]));
    end
endmodule

// File: rtl/perf_monitor.sv
// perf_monitor: two selectable event counters and one cycle counter behind a
// four-address register port, with sticky overflow flags and one interrupt.
// Assumes CNT_W <= 32 and that event pulses are synchronous to clk.
module perf_monitor
    import pmu_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int EVT_W    = 32,
    parameter int SEL_W    = 8,
    parameter int PRESCALE = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [EVT_W-1:0]  events,
    output logic              irq
);
    logic               run;
    logic               divide;
    logic               zero_ev;
    logic               zero_cyc;
    logic               tick;
    logic [SEL_W-1:0]   sel_ev0;
    logic [SEL_W-1:0]   sel_ev1;
    logic [CTRL_W-1:0]  ctrl_word;
    logic [NUM_CNT-1:0] wrap;
    logic [CNT_W-1:0]   count [NUM_CNT];
    logic               ctrl_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);

    pmu_ctrl #(.SEL_W(SEL_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (reg_wdata),
        .wrap     (wrap),
        .run      (run),
        .divide   (divide),
        .sel_ev0  (sel_ev0),
        .sel_ev1  (sel_ev1),
        .zero_ev  (zero_ev),
        .zero_cyc (zero_cyc),
        .word     (ctrl_word),
        .irq      (irq)
    );

    pmu_prescale #(.RATIO(PRESCALE)) u_prescale (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run && divide),
        .clear (zero_cyc),
        .tick  (tick)
    );

    for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
        logic step;
        logic clr;
        logic load;

        if (i == IDX_CYC) begin : g_cyc
            assign step = run && (divide ? tick : 1'b1);
            assign clr  = zero_cyc;
        end else begin : g_ev
            logic hit;
            pmu_evsel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
                .sel    ((i == IDX_EV0) ? sel_ev0 : sel_ev1),
                .events (events),
                .hit    (hit)
            );
            assign step = run && hit;
            assign clr  = zero_ev;
        end

        assign load = reg_wr && (reg_addr == slot_addr(i));

        pmu_counter #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (reg_wdata[CNT_W-1:0]),
            .clear    (clr),
            .inc      (step),
            .value    (count[i]),
            .wrap     (wrap[i])
        );

        // R2
        hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!run && !reg_wr) |=> $stable(count[i]));
    end

    // Return the addressed register.
    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = ctrl_word;
            ADDR_CYC:  reg_rdata = 32'(count[IDX_CYC]);
            ADDR_EV0:  reg_rdata = 32'(count[IDX_EV0]);
            default:   reg_rdata = 32'(count[IDX_EV1]);
        endcase
    end
endmodule

// File: tb/perf_monitor_test.sv
`timescale 1ns/1ps
module perf_monitor_test;
    localparam int PSC = 8;
    localparam int NT  = 5;

    // Table: sel0, sel1, event pattern, pulse cycles, expected count0, count1.
    localparam logic [7:0]  T_S0 [NT] = '{8'd3, 8'd0, 8'h20, 8'd40, 8'd31};
    localparam logic [7:0]  T_S1 [NT] = '{8'd5, 8'd31, 8'd17, 8'd12, 8'd31};
    localparam logic [31:0] T_EV [NT] = '{32'h0000_0008, 32'h8000_0001,
                                          32'hFFFF_FFFF, 32'h0000_1000, 32'h7FFF_FFFF};
    localparam int          T_N  [NT] = '{10, 7, 5, 9, 6};
    localparam int          T_E0 [NT] = '{10, 7, 0, 0, 0};
    localparam int          T_E1 [NT] = '{0, 7, 5, 9, 0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] events = '0;
    logic        irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    perf_monitor #(.PRESCALE(PSC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .events(events), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.2;
        d = reg_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset read", v, 32'h0);
        end
        check("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2 disabled: pulses on a selected line do not count
        wr(2'd0, 32'h0030_0002);
        events = 32'h8;
        repeat (5) @(negedge clk);
        events = '0;
        rd(2'd2, v);
        check("R2 no count when disabled", v, 32'h0);

        // R3 select table
        for (int k = 0; k < NT; k++) begin
            wr(2'd0, 32'h3 | (32'(T_S0[k]) << 20) | (32'(T_S1[k]) << 12));
            events = T_EV[k];
            repeat (T_N[k]) @(negedge clk);
            events = '0;
            rd(2'd2, v);
            check("R3 table count0", v, 32'(T_E0[k]));
            rd(2'd3, v);
            check("R3 table count1", v, 32'(T_E1[k]));
        end

        // R3 code 0xFF counts every enabled clock (11 edges)
        wr(2'd0, 32'h0FF0_0003);
        repeat (10) @(negedge clk);
        wr(2'd0, 32'h0FF0_0000);
        rd(2'd2, v);
        check("R3 all-ones code", v, 32'd11);

        // R4 reset bits act separately and are not stored
        wr(2'd0, 32'h0);
        wr(2'd1, 32'd100);
        wr(2'd2, 32'd50);
        wr(2'd0, 32'h4);
        rd(2'd1, v);
        check("R4 cycle zeroed", v, 32'h0);
        rd(2'd2, v);
        check("R4 count0 kept", v, 32'd50);
        wr(2'd0, 32'h2);
        rd(2'd2, v);
        check("R4 count0 zeroed", v, 32'h0);
        rd(2'd0, v);
        check("R4 reset bits read 0", v, 32'h0);

        // R9 write wins over increment
        wr(2'd0, 32'h0FF0_0001);
        wr(2'd2, 32'd1234);
        rd(2'd2, v);
        check("R9 write priority", v, 32'd1234);
        @(negedge clk);
        rd(2'd2, v);
        check("R9 counts on after write", v, 32'd1235);
        wr(2'd0, 32'h0);

        // R6 event count 1 wrap sets bit 9; R8 gated by bit 5
        wr(2'd3, 32'hFFFF_FFFE);
        wr(2'd0, 32'h0200_4001);
        events = 32'h10;
        repeat (2) @(negedge clk);
        events = '0;
        rd(2'd3, v);
        check("R6 count1 wrapped", v, 32'h0);
        rd(2'd0, v);
        check("R6 flag bit9", v & 32'h700, 32'h200);
        check("R8 irq masked", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0200_4021);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);
        rd(2'd0, w);
        check("R7 zero write keeps flag", w, 32'h0200_4221);
        wr(2'd0, w);
        rd(2'd0, v);
        check("R7 writeback clears flag", v, 32'h0200_4021);
        check("R8 irq after clear", {31'b0, irq}, 32'h0);

        // R5 prescaler: ticks at the 8th and 16th edge
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h0202_000D);
        repeat (17) @(negedge clk);
        rd(2'd1, v);
        check("R5 prescaled cycles", v, 32'd2);
        wr(2'd0, 32'h0202_0000);
        repeat (4) @(negedge clk);
        rd(2'd1, v);
        check("R2 cycle frozen", v, 32'd2);

        // R6 cycle wrap sets bit 10; R8 via bit 6
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd0, 32'h0202_0041);
        @(negedge clk);
        rd(2'd1, v);
        check("R6 cycle wrapped", v, 32'h0);
        rd(2'd0, v);
        check("R6 flag bit10", v & 32'h700, 32'h400);
        check("R8 irq cycle", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0202_0440);
        rd(2'd0, v);
        check("R7 one write clears bit10", v & 32'h700, 32'h0);
        check("R8 irq dropped", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule